// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It drives the analog front end through its phases with a 2-bit phase select. It watches the front end's single comparator output and turns the comparator's timing into a signed count. Between conversions the front end sits in auto-zero. A start pulse runs one conversion, in this order:

- a programmable auto-zero stretch;
- an input integration of programmable length, at whose end the input polarity is taken from the comparator;
- a reference deintegration, timed until the comparator falls;
- an integrator-zero phase, which drains overshoot charge until the comparator rises again.

The comparator is asynchronous to the clock and passes through a two-stage synchronizer. The deintegration count is corrected for that fixed latency, so the result counts clock cycles of true deintegration time. Two fault paths end a conversion cleanly:

- If deintegration runs too long, the result saturates and an overrange flag is raised.
- If the integrator-zero phase never sees the comparator rise, a timeout returns the block to auto-zero and raises an error flag.

Top module: `dualslope_seq`

## Requirements
- R1: After reset the phase select reads 2'b01 (auto-zero, bit 1 = A, bit 0 = B), busy and done are low and the result is zero; with no start pulse the block stays there.
- R2: A start pulse is accepted only while busy is low. Busy rises on the next clock with phase 2'b01 and falls only when the conversion ends. A start pulse while busy has no effect on the conversion's phase lengths or result.
- R3: The start-of-conversion auto-zero (phase 2'b01 with busy high) lasts max(az_len, 1) clocks, using the length present at the start pulse.
- R4: Input integration (phase 2'b10) follows and lasts max(int_len, 1) clocks, using the length present at the start pulse.
- R5: Polarity is the synchronized comparator level in the last integration clock: 1 means positive input, 0 means negative. Comparator changes earlier in integration neither end the phase nor change the result.
- R6: Deintegration (phase 2'b11) follows. If cmp_i is driven low N clocks after the phase begins, and was high before that, the magnitude is N and the phase lasts N+3 clocks (two synchronizer stages plus one edge-detect clock).
- R7: If no falling edge is seen within MAX_CNT counts, deintegration lasts MAX_CNT+1 clocks. The magnitude saturates at MAX_CNT, overrange is set, and the integrator-zero phase still follows.
- R8: Integrator zero (phase 2'b00) ends on the clock after the synchronized comparator is seen high. If cmp_i rises k clocks into the phase, the phase lasts k+3 clocks; the exit goes to phase 2'b01.
- R9: If the synchronized comparator stays low for IOZ_MAX clocks of integrator zero, the block returns to auto-zero with the zero-error flag set.
- R10: Done pulses for one clock on the first idle clock. In that same clock, result reads +magnitude for polarity 1 and −magnitude for polarity 0, in two's complement, and polarity, overrange and zero-error are valid. All of these hold until the next done.
- R11: The phase select only moves in the order 01 → 10 → 11 → 00 → 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-conversion pulse |
| cmp_i | input | 1 | Asynchronous comparator output from the front end |
| az_len_i | input | LEN_W | Auto-zero length in clocks (0 treated as 1) |
| int_len_i | input | LEN_W | Integration length in clocks (0 treated as 1) |
| phase_o | output | 2 | Phase select, bit 1 = A, bit 0 = B |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock end-of-conversion strobe |
| polarity_o | output | 1 | Input polarity of the last conversion (1 = positive) |
| result_o | output | RW | Signed deintegration count of the last conversion |
| overrange_o | output | 1 | Last conversion saturated |
| zero_err_o | output | 1 | Last integrator-zero phase timed out |

## Verification
The bound checker watches the phase order and the start/busy/done handshake on every clock. On every clock it also checks the following:
- the integrator-zero exit is backed by a high synchronized comparator, unless the exit is a timeout;
- the saturated magnitude is right whenever overrange is reported;
- the result holds between conversions.

The length of each phase, the synchronizer-corrected count and the sign of the result can only be shown by the bench's scenarios. These scenarios count the phase clocks and drive comparator edges at chosen offsets, including at the timeout boundary and with comparator glitches early in integration.

// File: rtl/dsadc_pkg.sv
`timescale 1ns/1ps
package dsadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AZ,
    ST_INT,
    ST_DEINT,
    ST_IOZ
  } ctl_st_t;

  // Phase select code driven to the front end for a controller state.
  function automatic logic [1:0] ph_of(ctl_st_t s);
    case (s)
      ST_INT:   return 2'b10;
      ST_DEINT: return 2'b11;
      ST_IOZ:   return 2'b00;
      default:  return 2'b01;
    endcase
  endfunction

  // Legal successor of a phase code.
  function automatic logic [1:0] ph_next(logic [1:0] p);
    case (p)
      2'b01:   return 2'b10;
      2'b10:   return 2'b11;
      2'b11:   return 2'b00;
      default: return 2'b01;
    endcase
  endfunction

  // A programmed length of zero behaves as one clock.
  function automatic int unsigned min_one(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Remove the fixed comparator path latency from a raw count.
  function automatic int unsigned corr_count(int unsigned raw, int unsigned lat);
    return (raw >= lat) ? raw - lat : 0;
  endfunction

  // Apply polarity to a magnitude.
  function automatic int signed_mag(logic positive, int unsigned m);
    return positive ? int'(m) : -int'(m);
  endfunction

endpackage

// File: rtl/dsadc_cmp_sync.sv
`timescale 1ns/1ps
module dsadc_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_i,
  output logic lvl_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= cmp_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];
  end

  assign lvl_o  = chain[STAGES-1];
  assign fall_o = prev_q & ~chain[STAGES-1];

endmodule

// File: rtl/dsadc_phase_ctl.sv
`timescale 1ns/1ps
module dsadc_phase_ctl
  import dsadc_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MAX_CNT = 1000,
  parameter int IOZ_MAX = 64,
  parameter int CNT_W   = $clog2(MAX_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_lvl,
  input  logic             cmp_fall,
  input  logic [LEN_W-1:0] az_len_i,
  input  logic [LEN_W-1:0] int_len_i,
  output logic [1:0]       phase_o,
  output logic             busy_o,
  output logic             int_last,
  output logic             deint_fall,
  output logic             deint_ovr,
  output logic             ioz_tmo,
  output logic             conv_end,
  output logic [CNT_W-1:0] dcnt_o
);

  localparam int ZW = (IOZ_MAX > 2) ? $clog2(IOZ_MAX) : 1;

  ctl_st_t          st;
  logic [LEN_W-1:0] tmr, az_q, int_q, az_eff, int_eff;
  logic [CNT_W-1:0] dcnt;
  logic [ZW-1:0]    ztmr;
  logic             az_last, ioz_ok, start_ok;

  assign az_eff  = LEN_W'(min_one(32'(az_q)));
  assign int_eff = LEN_W'(min_one(32'(int_q)));

  assign start_ok   = (st == ST_IDLE) && start_i;
  assign az_last    = (st == ST_AZ)  && (tmr == az_eff - LEN_W'(1));
  assign int_last   = (st == ST_INT) && (tmr == int_eff - LEN_W'(1));
  assign deint_fall = (st == ST_DEINT) && cmp_fall;
  assign deint_ovr  = (st == ST_DEINT) && !cmp_fall && (dcnt == CNT_W'(MAX_CNT));
  assign ioz_ok     = (st == ST_IOZ) && cmp_lvl;
  assign ioz_tmo    = (st == ST_IOZ) && !cmp_lvl && (ztmr == ZW'(IOZ_MAX - 1));
  assign conv_end   = ioz_ok || ioz_tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      tmr   <= '0;
      az_q  <= '0;
      int_q <= '0;
      dcnt  <= '0;
      ztmr  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_ok) begin
            st    <= ST_AZ;
            tmr   <= '0;
            az_q  <= az_len_i;
            int_q <= int_len_i;
          end
        end
        ST_AZ: begin
          if (az_last) begin
            st  <= ST_INT;
            tmr <= '0;
          end else begin
            tmr <= tmr + LEN_W'(1);
          end
        end
        ST_INT: begin
          if (int_last) begin
            st   <= ST_DEINT;
            dcnt <= '0;
          end else begin
            tmr <= tmr + LEN_W'(1);
          end
        end
        ST_DEINT: begin
          if (deint_fall || deint_ovr) begin
            st   <= ST_IOZ;
            ztmr <= '0;
          end else begin
            dcnt <= dcnt + CNT_W'(1);
          end
        end
        ST_IOZ: begin
          if (conv_end) st <= ST_IDLE;
          else          ztmr <= ztmr + ZW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign phase_o = ph_of(st);
  assign busy_o  = (st != ST_IDLE);
  assign dcnt_o  = dcnt;

endmodule

// File: rtl/dsadc_result.sv
`timescale 1ns/1ps
module dsadc_result
  import dsadc_pkg::*;
#(
  parameter int MAX_CNT  = 1000,
  parameter int SYNC_LAT = 2,
  parameter int CNT_W    = $clog2(MAX_CNT + 1),
  parameter int RW       = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_last,
  input  logic             cmp_lvl,
  input  logic             deint_fall,
  input  logic             deint_ovr,
  input  logic [CNT_W-1:0] dcnt,
  input  logic             conv_end,
  input  logic             ioz_tmo,
  output logic             done_o,
  output logic             polarity_o,
  output logic [RW-1:0]    result_o,
  output logic             overrange_o,
  output logic             zero_err_o
);

  logic             pol_q, ovr_q;
  logic [CNT_W-1:0] mag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
      ovr_q <= 1'b0;
      mag_q <= '0;
    end else begin
      if (int_last) pol_q <= cmp_lvl;
      if (deint_fall) begin
        mag_q <= CNT_W'(corr_count(32'(dcnt), SYNC_LAT));
        ovr_q <= 1'b0;
      end else if (deint_ovr) begin
        mag_q <= CNT_W'(MAX_CNT);
        ovr_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      polarity_o  <= 1'b0;
      result_o    <= '0;
      overrange_o <= 1'b0;
      zero_err_o  <= 1'b0;
    end else begin
      done_o <= conv_end;
      if (conv_end) begin
        polarity_o  <= pol_q;
        result_o    <= RW'(signed_mag(pol_q, 32'(mag_q)));
        overrange_o <= ovr_q;
        zero_err_o  <= ioz_tmo;
      end
    end
  end

endmodule

// File: rtl/dualslope_seq.sv
`timescale 1ns/1ps
module dualslope_seq #(
  parameter int LEN_W       = 16,
  parameter int MAX_CNT     = 1000,
  parameter int IOZ_MAX     = 64,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(MAX_CNT + 1),
  localparam int RW         = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic [LEN_W-1:0] az_len_i,
  input  logic [LEN_W-1:0] int_len_i,
  output logic [1:0]       phase_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             polarity_o,
  output logic [RW-1:0]    result_o,
  output logic             overrange_o,
  output logic             zero_err_o
);

  // Named internal events, visible to the bound checker.
  logic             cmp_lvl, cmp_fall;
  logic             int_last, deint_fall, deint_ovr, ioz_tmo, conv_end;
  logic [CNT_W-1:0] dcnt;

  dsadc_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmp_i  (cmp_i),
    .lvl_o  (cmp_lvl),
    .fall_o (cmp_fall)
  );

  dsadc_phase_ctl #(
    .LEN_W   (LEN_W),
    .MAX_CNT (MAX_CNT),
    .IOZ_MAX (IOZ_MAX),
    .CNT_W   (CNT_W)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmp_lvl    (cmp_lvl),
    .cmp_fall   (cmp_fall),
    .az_len_i   (az_len_i),
    .int_len_i  (int_len_i),
    .phase_o    (phase_o),
    .busy_o     (busy_o),
    .int_last   (int_last),
    .deint_fall (deint_fall),
    .deint_ovr  (deint_ovr),
    .ioz_tmo    (ioz_tmo),
    .conv_end   (conv_end),
    .dcnt_o     (dcnt)
  );

  dsadc_result #(
    .MAX_CNT  (MAX_CNT),
    .SYNC_LAT (SYNC_STAGES),
    .CNT_W    (CNT_W),
    .RW       (RW)
  ) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_last    (int_last),
    .cmp_lvl     (cmp_lvl),
    .deint_fall  (deint_fall),
    .deint_ovr   (deint_ovr),
    .dcnt        (dcnt),
    .conv_end    (conv_end),
    .ioz_tmo     (ioz_tmo),
    .done_o      (done_o),
    .polarity_o  (polarity_o),
    .result_o    (result_o),
    .overrange_o (overrange_o),
    .zero_err_o  (zero_err_o)
  );

endmodule

// File: rtl/dualslope_seq_chk.sv
`timescale 1ns/1ps
module dualslope_seq_chk
  import dsadc_pkg::*;
#(
  parameter int MAX_CNT = 1000,
  localparam int RW     = $clog2(MAX_CNT + 1) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          cmp_lvl,
  input logic [1:0]    phase_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          overrange_o,
  input logic          zero_err_o,
  input logic [RW-1:0] result_o
);

  // R11
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |-> (phase_o == ph_next($past(phase_o))));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && phase_o == 2'b01));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |-> $stable(result_o));

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && phase_o == 2'b01));

  // R2
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && phase_o != 2'b00) |=> busy_o);

  // R7
  ovr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && overrange_o) |->
      (result_o == RW'(MAX_CNT) || result_o == RW'(-MAX_CNT)));

  // R8
  ioz_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_o) == 2'b00 && phase_o == 2'b01 && !zero_err_o) |-> $past(cmp_lvl));

  // R9
  ioz_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && zero_err_o) |-> ($past(phase_o) == 2'b00 && !$past(cmp_lvl)));

endmodule

bind dualslope_seq dualslope_seq_chk #(.MAX_CNT(MAX_CNT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .cmp_lvl     (cmp_lvl),
  .phase_o     (phase_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .overrange_o (overrange_o),
  .zero_err_o  (zero_err_o),
  .result_o    (result_o)
);

// File: tb/dualslope_seq_test.sv
`timescale 1ns/1ps
module dualslope_seq_test;

  localparam int LW   = 16;
  localparam int MAXC = 1000;
  localparam int IOZM = 64;
  localparam int RW   = $clog2(MAXC + 1) + 1;

  logic          clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, cmp_i = 1'b0;
  logic [LW-1:0] az_len = '0, int_len = '0;
  logic [1:0]    phase_o;
  logic          busy_o, done_o, polarity_o, overrange_o, zero_err_o;
  logic [RW-1:0] result_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dualslope_seq #(.LEN_W(LW), .MAX_CNT(MAXC), .IOZ_MAX(IOZM), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .az_len_i(az_len), .int_len_i(int_len),
    .phase_o(phase_o), .busy_o(busy_o), .done_o(done_o),
    .polarity_o(polarity_o), .result_o(result_o),
    .overrange_o(overrange_o), .zero_err_o(zero_err_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int at_least1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int exp_ioz(bit ovr, bit never, int k);
    if (ovr) return 1;
    if (never || k + 3 > IOZM) return IOZM;
    return k + 3;
  endfunction

  // One conversion; the bench plays the front end's comparator.
  task automatic convert(int az, int il, bit pos, int n, int k, bit ovr, bit never, bit poke);
    int c_az, c_int, c_de, c_z, guard, il_c, mag, res;
    bit err;
    il_c = at_least1(il);
    c_az = 0; c_int = 0; c_de = 0; c_z = 0; guard = 0;
    cmp_i = pos; az_len = LW'(az); int_len = LW'(il);
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && guard < 5000) begin
      case (phase_o)
        2'b01: c_az++;
        2'b10: begin
          start_i = (poke && c_int == 0);
          if (il_c >= 6 && c_int == 0) cmp_i = !pos;
          if (il_c >= 6 && c_int == 1) cmp_i = pos;
          c_int++;
        end
        2'b11: begin
          start_i = 1'b0;
          if (c_de == 0 && !pos) cmp_i = 1'b1;
          if (!ovr && c_de == n) cmp_i = 1'b0;
          c_de++;
        end
        default: begin
          if (!never && !ovr && c_z == k) cmp_i = 1'b1;
          c_z++;
        end
      endcase
      guard++;
      @(negedge clk);
    end
    if (!done_o) begin
      n_chk++; n_bad++;
      $display("FAIL R10 no done strobe actual=0 expected=1");
      return;
    end
    mag = ovr ? MAXC : n;
    res = pos ? mag : -mag;
    err = !ovr && (never || k + 3 > IOZM);
    chk("R2 busy low at done", busy_o, 0);
    chk("R3 auto-zero clocks", c_az, at_least1(az));
    chk("R4 integration clocks", c_int, il_c);
    chk(ovr ? "R7 deintegration clocks" : "R6 deintegration clocks", c_de, ovr ? MAXC + 1 : n + 3);
    chk(err ? "R9 integrator-zero clocks" : "R8 integrator-zero clocks", c_z, exp_ioz(ovr, never, k));
    chk("R5 polarity", polarity_o, pos);
    chk("R10 signed result", $signed(result_o), res);
    chk("R7 overrange flag", overrange_o, ovr);
    chk("R9 zero error flag", zero_err_o, err);
    @(negedge clk);
    chk("R10 done one clock", done_o, 0);
    @(negedge clk);
    chk("R10 result held", $signed(result_o), res);
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset phase", phase_o, 1);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset done", done_o, 0);
    chk("R1 reset result", result_o, 0);
    repeat (5) @(negedge clk);
    chk("R1 idle without start", {30'd0, busy_o, phase_o == 2'b01}, 1);

    convert(0, 0, 1'b1, 0, 0, 1'b0, 1'b0, 1'b0);    // minimal lengths
    convert(5, 10, 1'b0, 1, 0, 1'b0, 1'b0, 1'b0);   // negative, shortest fall
    convert(3, 8, 1'b1, 20, 2, 1'b0, 1'b0, 1'b0);
    convert(4, 12, 1'b1, 0, 0, 1'b1, 1'b0, 1'b0);   // R7 positive overrange
    convert(4, 12, 1'b0, 0, 0, 1'b1, 1'b0, 1'b0);   // R7 negative overrange
    convert(2, 7, 1'b1, 5, 0, 1'b0, 1'b1, 1'b0);    // R9 comparator never rises
    convert(2, 7, 1'b1, 5, IOZM - 3, 1'b0, 1'b0, 1'b0); // R8 rise on last allowed clock
    convert(2, 7, 1'b0, 5, IOZM - 2, 1'b0, 1'b0, 1'b0); // R9 rise one clock late
    convert(6, 9, 1'b1, 15, 1, 1'b0, 1'b0, 1'b1);   // R2 start while busy

    for (int i = 0; i < 40; i++) begin
      bit p;
      p = 1'($urandom_range(0, 1));
      convert(int'($urandom_range(0, 20)), int'($urandom_range(0, 40)), p,
              p ? int'($urandom_range(0, 80)) : int'($urandom_range(1, 80)),
              int'($urandom_range(0, 10)), 1'b0, 1'b0, 1'($urandom_range(0, 1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule